// File: doc/BRIEF.md
# User Memory Block Write-Lock Controller

This block holds the write-protection state of a user memory that is divided into five blocks, and it answers whether a given write may proceed. The state lives in one 16-bit lock word. Two low bits of that word carry device configuration, and five bits carry one permanent-lock flag per block. A host processor updates the word with whole-word writes. A radio-side command path can set lock flags, but only while an enable input, which only the host controls, is high.

Lock flags for blocks 1 to 4 only accumulate. A host write ORs its new flags into the stored ones, and a radio command can only add flags. The block 0 flag is the exception. The host may set or clear it, and host writes into block 0 disregard it. Each write query carries a starting bit address, a one-word or two-word length and the requesting port. The controller maps the touched bit range onto blocks and returns a registered allow or deny result one clock later.

Top module: `ublk_lock_ctrl`

## Requirements
- R1: After synchronous reset the lock word is 0x0002: configuration bits [1:0] = 2'b10, every other bit 0, no block locked. `chk_valid` is low.
- R2: A host word write keeps bits [1:0] of the stored word and takes every other bit from the written data, so the result is (old AND 0x0003) OR (new AND 0xFFFC). The block flags [12:9] then follow R3.
- R3: Block lock flags sit at bit 8 + n for block n. For blocks 1 to 4 (bits 12:9), a host write stores the OR of the old and new flags, so these flags are never cleared.
- R4: A host write stores data bit 8 directly as the block 0 flag, so the host can both set and clear it.
- R5: A radio command ORs `rdr_pl_mask` (bit n for block n) into bits 12:8 only while `bpl_enable` is high. While `bpl_enable` is low the lock word is unchanged. A command never clears a flag, including the flag for block 0.
- R6: When a host write and an enabled radio command arrive in the same cycle, the radio mask is ORed on top of the result of the host merge.
- R7: A query with `chk_en` high gives `chk_valid` high on the next cycle, with `chk_allow` as its result.
- R8: Block n covers bit addresses 512n to 512n+511 for n = 0 to 3, and block 4 covers bits 2048 to 2175. A query that touches a locked block is denied for both ports (`chk_port` 0 = host, 1 = radio), except that a host query ignores the block 0 flag.
- R9: A query covers 16 bits, or 32 bits when `chk_two_word` is 1. A query whose range spans two blocks is denied if either block is locked for that port.
- R10: A query whose last bit lies beyond bit 2175 is denied.
- R11: Bit 2 of the lock word is a radio-only user-memory write lock. While it is set, every radio query is denied, and host queries do not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host whole-word write to the lock word |
| host_wr_data | input | 16 | Host write data |
| rdr_pl_en | input | 1 | Radio permanent-lock command strobe |
| rdr_pl_mask | input | 5 | Blocks to lock, bit n = block n |
| bpl_enable | input | 1 | Host-owned enable for radio lock commands |
| chk_en | input | 1 | Write-permission query strobe |
| chk_addr | input | 12 | Query start bit address |
| chk_two_word | input | 1 | 1 = two-word query, 0 = one word |
| chk_port | input | 1 | Requesting port, 0 host, 1 radio |
| chk_valid | output | 1 | Registered query result valid |
| chk_allow | output | 1 | Registered result, 1 = write allowed |
| lock_word | output | 16 | Registered current lock word |

## Verification
The assertions assume that the decoded control strobes are single-cycle pulses sampled on the rising edge. They also assume that the reset is held for more than one clock, so that every history term starts from the reset word. They place no limit on addresses, because the check for the out-of-range case recomputes the end of the range independently of the decoder. The stimulus drives all inputs on the falling edge, drops each strobe after one cycle and holds reset for three cycles. It reaches the block edges exactly (bits 496, 992, 1008, 2160 and 2176), so that the spanning and range corners are exercised without ambiguity.

// File: rtl/ublk_lock_pkg.sv
package ublk_lock_pkg;
  localparam int unsigned UB_NUM_BLK   = 5;
  localparam int unsigned UB_BLK_BITS  = 512;
  localparam int unsigned UB_LAST_BITS = 128;
  localparam int unsigned UB_WORD_W    = 16;
  localparam int unsigned UB_ADDR_W    = 12;
  localparam int unsigned UB_LOCK_LSB  = 8;
  localparam int unsigned UB_WLOCK_BIT = 2;
  localparam int unsigned UB_CFG_W     = 2;

  typedef enum logic {
    PORT_HOST = 1'b0,
    PORT_RDR  = 1'b1
  } ub_port_e;
endpackage

// File: rtl/ublk_span_decode.sv
module ublk_span_decode #(
  parameter int unsigned NUM_BLK   = 5,
  parameter int unsigned BLK_BITS  = 512,
  parameter int unsigned LAST_BITS = 128,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               two_word,
  output logic [NUM_BLK-1:0] blk_mask,
  output logic               in_range
);
  localparam int unsigned TOTAL = (NUM_BLK - 1) * BLK_BITS + LAST_BITS;
  localparam int unsigned SH    = $clog2(BLK_BITS);
  localparam int unsigned XW    = ADDR_W + 1;
  localparam logic [XW-1:0] TOP_IDX = XW'(NUM_BLK - 1);

  logic [XW-1:0] first_bit, last_bit;
  logic [XW-1:0] first_raw, last_raw;
  logic [XW-1:0] first_idx, last_idx;

  always_comb begin
    first_bit = {1'b0, addr};
    last_bit  = first_bit + (two_word ? XW'(2 * WORD_W - 1) : XW'(WORD_W - 1));
    in_range  = (last_bit < XW'(TOTAL));
    first_raw = first_bit >> SH;
    last_raw  = last_bit >> SH;
    first_idx = (first_raw > TOP_IDX) ? TOP_IDX : first_raw;
    last_idx  = (last_raw > TOP_IDX) ? TOP_IDX : last_raw;
  end

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    assign blk_mask[i] = (XW'(i) >= first_idx) && (XW'(i) <= last_idx);
  end
endmodule

// File: rtl/ublk_lock_merge.sv
module ublk_lock_merge #(
  parameter int unsigned NUM_BLK  = 5,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned LOCK_LSB = 8,
  parameter int unsigned CFG_W    = 2
) (
  input  logic [WORD_W-1:0]  cur_word,
  input  logic               host_wr,
  input  logic [WORD_W-1:0]  host_data,
  input  logic               rdr_cmd,
  input  logic               rdr_enable,
  input  logic [NUM_BLK-1:0] rdr_mask,
  output logic [WORD_W-1:0]  nxt_word
);
  localparam logic [WORD_W-1:0] KEEP = WORD_W'((1 << CFG_W) - 1);

  logic [WORD_W-1:0] staged;

  always_comb begin
    staged = cur_word;
    if (host_wr) begin
      staged = (cur_word & KEEP) | (host_data & ~KEEP);
      // blocks 1.. accumulate; block 0 taken as written
      staged[LOCK_LSB+1 +: NUM_BLK-1] = host_data[LOCK_LSB+1 +: NUM_BLK-1]
                                      | cur_word[LOCK_LSB+1 +: NUM_BLK-1];
    end
    nxt_word = staged;
    if (rdr_cmd && rdr_enable) begin
      nxt_word[LOCK_LSB +: NUM_BLK] = staged[LOCK_LSB +: NUM_BLK] | rdr_mask;
    end
  end
endmodule

// File: rtl/ublk_write_gate.sv
module ublk_write_gate
  import ublk_lock_pkg::*;
#(
  parameter int unsigned NUM_BLK = 5
) (
  input  logic [NUM_BLK-1:0] lock_bits,
  input  logic [NUM_BLK-1:0] blk_mask,
  input  logic               in_range,
  input  logic               rdr_wlock,
  input  ub_port_e           port,
  output logic               allow
);
  logic [NUM_BLK-1:0] eff_lock;

  always_comb begin
    eff_lock = lock_bits;
    if (port == PORT_HOST) eff_lock[0] = 1'b0;
    allow = in_range
         && ((eff_lock & blk_mask) == '0)
         && !((port == PORT_RDR) && rdr_wlock);
  end
endmodule

// File: rtl/ublk_lock_ctrl.sv
module ublk_lock_ctrl
  import ublk_lock_pkg::*;
#(
  parameter int unsigned NUM_BLK       = UB_NUM_BLK,
  parameter int unsigned BLK_BITS      = UB_BLK_BITS,
  parameter int unsigned LAST_BITS     = UB_LAST_BITS,
  parameter int unsigned WORD_W        = UB_WORD_W,
  parameter int unsigned ADDR_W        = UB_ADDR_W,
  parameter int unsigned LOCK_LSB      = UB_LOCK_LSB,
  parameter int unsigned WLOCK_BIT     = UB_WLOCK_BIT,
  parameter int unsigned CFG_W         = UB_CFG_W,
  parameter logic [CFG_W-1:0] CFG_RESET = 2'b10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic [WORD_W-1:0]  host_wr_data,
  input  logic               rdr_pl_en,
  input  logic [NUM_BLK-1:0] rdr_pl_mask,
  input  logic               bpl_enable,
  input  logic               chk_en,
  input  logic [ADDR_W-1:0]  chk_addr,
  input  logic               chk_two_word,
  input  logic               chk_port,
  output logic               chk_valid,
  output logic               chk_allow,
  output logic [WORD_W-1:0]  lock_word
);
  localparam logic [WORD_W-1:0] RESET_WORD = {{(WORD_W-CFG_W){1'b0}}, CFG_RESET};

  logic [WORD_W-1:0]  lock_q, lock_d;
  logic [NUM_BLK-1:0] blk_mask;
  logic               in_range, allow_c;
  logic               valid_q, allow_q;

  ublk_lock_merge #(
    .NUM_BLK(NUM_BLK), .WORD_W(WORD_W), .LOCK_LSB(LOCK_LSB), .CFG_W(CFG_W)
  ) u_merge (
    .cur_word  (lock_q),
    .host_wr   (host_wr_en),
    .host_data (host_wr_data),
    .rdr_cmd   (rdr_pl_en),
    .rdr_enable(bpl_enable),
    .rdr_mask  (rdr_pl_mask),
    .nxt_word  (lock_d)
  );

  ublk_span_decode #(
    .NUM_BLK(NUM_BLK), .BLK_BITS(BLK_BITS), .LAST_BITS(LAST_BITS),
    .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr    (chk_addr),
    .two_word(chk_two_word),
    .blk_mask(blk_mask),
    .in_range(in_range)
  );

  ublk_write_gate #(
    .NUM_BLK(NUM_BLK)
  ) u_gate (
    .lock_bits(lock_q[LOCK_LSB +: NUM_BLK]),
    .blk_mask (blk_mask),
    .in_range (in_range),
    .rdr_wlock(lock_q[WLOCK_BIT]),
    .port     (ub_port_e'(chk_port)),
    .allow    (allow_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= RESET_WORD;
      valid_q <= 1'b0;
      allow_q <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      valid_q <= chk_en;
      allow_q <= chk_en && allow_c;
    end
  end

  assign lock_word = lock_q;
  assign chk_valid = valid_q;
  assign chk_allow = allow_q;
endmodule

// File: rtl/ublk_lock_ctrl_chk.sv
module ublk_lock_ctrl_chk #(
  parameter int unsigned NUM_BLK   = 5,
  parameter int unsigned BLK_BITS  = 512,
  parameter int unsigned LAST_BITS = 128,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LOCK_LSB  = 8,
  parameter int unsigned CFG_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr_en,
  input logic              rdr_pl_en,
  input logic              bpl_enable,
  input logic              chk_en,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              chk_two_word,
  input logic              chk_valid,
  input logic              chk_allow,
  input logic [WORD_W-1:0] lock_word
);
  localparam int unsigned TOTAL = (NUM_BLK - 1) * BLK_BITS + LAST_BITS;
  localparam int unsigned HI    = LOCK_LSB + NUM_BLK - 1;
  localparam int unsigned LO    = LOCK_LSB + 1;

  logic [ADDR_W:0] end_excl;
  assign end_excl = {1'b0, chk_addr} + (chk_two_word ? (ADDR_W+1)'(2*WORD_W) : (ADDR_W+1)'(WORD_W));

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (rst)
    lock_word[CFG_W-1:0] == $past(lock_word[CFG_W-1:0])); // R2

  AST_STICKY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_word[HI:LO]) & ~lock_word[HI:LO]) == '0)); // R3

  AST_RDR_GATED: assert property (@(posedge clk) disable iff (rst)
    (rdr_pl_en && !bpl_enable && !host_wr_en) |=> $stable(lock_word)); // R5

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    chk_en |=> chk_valid); // R7

  AST_RANGE_DENY: assert property (@(posedge clk) disable iff (rst)
    (chk_en && (end_excl > (ADDR_W+1)'(TOTAL))) |=> !chk_allow); // R10
endmodule

bind ublk_lock_ctrl ublk_lock_ctrl_chk #(
  .NUM_BLK(NUM_BLK), .BLK_BITS(BLK_BITS), .LAST_BITS(LAST_BITS),
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LOCK_LSB(LOCK_LSB), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .rdr_pl_en(rdr_pl_en),
  .bpl_enable(bpl_enable), .chk_en(chk_en), .chk_addr(chk_addr),
  .chk_two_word(chk_two_word), .chk_valid(chk_valid), .chk_allow(chk_allow),
  .lock_word(lock_word)
);

// File: tb/ublk_lock_ctrl_bench.sv
module ublk_lock_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [15:0] host_wr_data = '0;
  logic        rdr_pl_en = 1'b0;
  logic [4:0]  rdr_pl_mask = '0;
  logic        bpl_enable = 1'b0;
  logic        chk_en = 1'b0;
  logic [11:0] chk_addr = '0;
  logic        chk_two_word = 1'b0;
  logic        chk_port = 1'b0;
  logic        chk_valid, chk_allow;
  logic [15:0] lock_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ublk_lock_ctrl u_ublk_lock_ctrl (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .rdr_pl_en(rdr_pl_en), .rdr_pl_mask(rdr_pl_mask), .bpl_enable(bpl_enable),
    .chk_en(chk_en), .chk_addr(chk_addr), .chk_two_word(chk_two_word),
    .chk_port(chk_port), .chk_valid(chk_valid), .chk_allow(chk_allow),
    .lock_word(lock_word)
  );

  task automatic expect_val(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_write(logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rdr_lock(logic [4:0] m, logic en);
    @(negedge clk);
    rdr_pl_en = 1'b1; rdr_pl_mask = m; bpl_enable = en;
    @(negedge clk);
    rdr_pl_en = 1'b0; rdr_pl_mask = '0;
  endtask

  task automatic query(string tag, int addr, logic two, logic port, logic exp);
    @(negedge clk);
    chk_en = 1'b1; chk_addr = 12'(addr); chk_two_word = two; chk_port = port;
    @(negedge clk);
    chk_en = 1'b0;
    expect_val({tag, " R7 valid"}, {15'd0, chk_valid}, 16'd1);
    expect_val(tag, {15'd0, chk_allow}, {15'd0, exp});
  endtask

  task automatic t_reset();
    do_reset();
    expect_val("R1 reset word", lock_word, 16'h0002);
    expect_val("R1 valid low", {15'd0, chk_valid}, 16'd0);
    query("R1 unlocked host", 0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_host_merge();
    do_reset();
    host_write(16'hFFFF);
    expect_val("R2 cfg kept", lock_word, 16'hFFFE);
    host_write(16'h0001);
    expect_val("R3 R4 sticky and block0 clear", lock_word, 16'h1E02);
  endtask

  task automatic t_reader();
    do_reset();
    rdr_lock(5'b11111, 1'b0);
    expect_val("R5 disabled ignored", lock_word, 16'h0002);
    rdr_lock(5'b00101, 1'b1);
    expect_val("R5 enabled sets", lock_word, 16'h0502);
    host_write(16'h0000);
    expect_val("R4 host clears block0", lock_word, 16'h0402);
    rdr_lock(5'b00000, 1'b1);
    expect_val("R5 no clear", lock_word, 16'h0402);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = 16'h0000;
    rdr_pl_en = 1'b1; rdr_pl_mask = 5'b00001; bpl_enable = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0; rdr_pl_en = 1'b0; rdr_pl_mask = '0;
    expect_val("R6 same cycle", lock_word, 16'h0502);
  endtask

  task automatic t_perm();
    do_reset();
    rdr_lock(5'b00100, 1'b1);
    expect_val("R5 block2 set", lock_word, 16'h0402);
    query("R8 host block2", 1024, 1'b0, 1'b0, 1'b0);
    query("R8 rdr block2", 1024, 1'b0, 1'b1, 1'b0);
    query("R8 host block1 free", 512, 1'b0, 1'b0, 1'b1);
    query("R9 span 1-2 denied", 1008, 1'b1, 1'b0, 1'b0);
    query("R9 end of block1", 992, 1'b1, 1'b1, 1'b1);
    host_write(16'h0100);
    expect_val("R4 host sets block0", lock_word, 16'h0502);
    query("R8 host bypass block0", 0, 1'b0, 1'b0, 1'b1);
    query("R8 rdr block0", 0, 1'b0, 1'b1, 1'b0);
    query("R9 host span 0-1", 496, 1'b1, 1'b0, 1'b1);
    query("R9 rdr span 0-1", 496, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_range();
    do_reset();
    query("R10 last word ok", 2160, 1'b0, 1'b0, 1'b1);
    query("R10 past end", 2160, 1'b1, 1'b0, 1'b0);
    query("R10 beyond", 2176, 1'b0, 1'b1, 1'b0);
    rdr_lock(5'b10000, 1'b1);
    expect_val("R5 block4 set", lock_word, 16'h1002);
    query("R8 block4 locked", 2048, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_wlock();
    do_reset();
    host_write(16'h0004);
    expect_val("R11 wlock stored", lock_word, 16'h0006);
    query("R11 rdr denied", 640, 1'b0, 1'b1, 1'b0);
    query("R11 host allowed", 640, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_host_merge();
    t_reader();
    t_perm();
    t_range();
    t_wlock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1-R11 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule